// File: doc/BRIEF.md
# Dual 8-bit Event Counter with Cascade

The block holds a low and a high up-counter, each `CW` bits wide (8 by default). Each counter advances on a count source picked by software. The choices are an external event pin or a tap of a free-running system-clock prescaler (/2, /4 or /8). Each event pin passes through a two-flop synchroniser and then a rising-edge detector, so one rising edge gives exactly one count.

The high counter can also be chained to the low counter. It then advances on the cycle in which the low counter wraps, and the pair forms one counter of twice the width, with the low counter as the least significant half.

Software reaches the block through a small register bus. A control register holds the source selects, the chaining bit and a run bit. Writing 0 to the run bit puts the block in standby. A command address clears either counter, and two read-only addresses return the counter values.

Top module: `evt_cnt_pair`

## Requirements
- R1: After reset both counters read 0 and the control register reads 0x20: both selects 00, chaining off, run bit 1.
- R2: The low counter's select field is control bits [1:0]. 00 counts low-pin events, 01 counts every 2nd clock, 10 every 4th and 11 every 8th. The count reads back at address 2.
- R3: The high counter's select field is control bits [3:2], with the same encoding as the low counter and the high pin in place of the low pin. The count reads back at address 3.
- R4: Each rising edge on an event pin adds exactly one count, however long the pin then stays high.
- R5: Writing address 1 with bit 0 set clears the low counter, and with bit 1 set clears the high counter. Each clear acts only on its own counter and wins over a count in the same cycle.
- R6: While the run bit (control bit 5) is 0, both counters hold their values and ignore every count source.
- R7: `ovf_lo_o` is high for exactly one cycle when the low counter wraps from all ones to 0.
- R8: When the chaining bit (control bit 4) is 1, the high counter advances on the low counter's wrap and not on its own select field. When the chaining bit is 0, the low counter's wrap does not affect the high counter.
- R9: Writes to the counter addresses (2 and 3) have no effect, and the count values can only be changed by counting or by clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_lo_i | input | 1 | Asynchronous event pin for the low counter |
| evt_hi_i | input | 1 | Asynchronous event pin for the high counter |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address: 0 control, 1 clear command, 2 low count, 3 high count |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| ovf_lo_o | output | 1 | One-cycle pulse on a low counter wrap |

## Verification
The bench builds the block with its default widths: an 8-bit counter, an 8-bit bus and a 2-bit address. With these widths a 576-cycle run at the /2 tap takes the low counter through one wrap and 32 further counts. That run is enough to check the single overflow pulse, the chained high byte and the unchained case side by side. Every prescaler window lasts a multiple of eight cycles, so the expected count does not depend on the prescaler's phase, and the bench can check each tap exactly.

// File: rtl/evt_cnt_pair.sv
module evt_cnt_pair #(
  parameter int CW = 8,
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_lo_i,
  input  logic          evt_hi_i,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ovf_lo_o
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CMD  = AW'(1);
  localparam logic [AW-1:0] A_LO   = AW'(2);
  localparam logic [AW-1:0] A_HI   = AW'(3);
  localparam int PW = 3;

  logic [1:0]    sel_lo, sel_hi;
  logic          casc_q, run_q;
  logic [CW-1:0] lo_q, hi_q;
  logic [2:0]    sy_lo, sy_hi;
  logic [PW-1:0] pre_q;
  logic          src_lo, src_hi, inc_lo, inc_hi, wrap;
  logic          clr_lo, clr_hi, wr_ctrl;
  logic [3:0]    taps_lo, taps_hi;

  assign wr_ctrl = bus_we && bus_addr == A_CTRL;
  assign clr_lo  = bus_we && bus_addr == A_CMD && bus_wdata[0];
  assign clr_hi  = bus_we && bus_addr == A_CMD && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_lo <= 2'b00;
      sel_hi <= 2'b00;
      casc_q <= 1'b0;
      run_q  <= 1'b1;
    end else if (wr_ctrl) begin
      sel_lo <= bus_wdata[1:0];
      sel_hi <= bus_wdata[3:2];
      casc_q <= bus_wdata[4];
      run_q  <= bus_wdata[5];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy_lo <= '0;
      sy_hi <= '0;
      pre_q <= '0;
    end else begin
      sy_lo <= {sy_lo[1:0], evt_lo_i};
      sy_hi <= {sy_hi[1:0], evt_hi_i};
      pre_q <= pre_q + 1'b1;
    end

  assign taps_lo = {&pre_q, &pre_q[1:0], pre_q[0], sy_lo[1] & ~sy_lo[2]};
  assign taps_hi = {&pre_q, &pre_q[1:0], pre_q[0], sy_hi[1] & ~sy_hi[2]};
  assign src_lo  = taps_lo[sel_lo];
  assign src_hi  = taps_hi[sel_hi];

  assign inc_lo   = run_q & src_lo;
  assign wrap     = inc_lo & (&lo_q) & ~clr_lo;
  assign inc_hi   = run_q & (casc_q ? wrap : src_hi);
  assign ovf_lo_o = wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lo_q <= '0;
    else if (clr_lo) lo_q <= '0;
    else if (inc_lo) lo_q <= lo_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      hi_q <= '0;
    else if (clr_hi) hi_q <= '0;
    else if (inc_hi) hi_q <= hi_q + 1'b1;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({run_q, casc_q, sel_hi, sel_lo});
      A_LO:    bus_rdata = DW'(lo_q);
      A_HI:    bus_rdata = DW'(hi_q);
      default: bus_rdata = '0;
    endcase

endmodule

// File: rtl/evt_cnt_pair_chk.sv
module evt_cnt_pair_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          casc,
  input logic          clr_lo,
  input logic          clr_hi,
  input logic          ovf,
  input logic [CW-1:0] lo,
  input logic [CW-1:0] hi
);

  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lo |=> (lo == $past(lo) || lo == CW'($past(lo) + 1'b1))); // R2

  AST_CLR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lo |=> lo == '0); // R5

  AST_CLR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hi |=> hi == '0); // R5

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr_lo && !clr_hi) |=> ($stable(lo) && $stable(hi))); // R6

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (!ovf && lo == '0)); // R7

  AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && casc && !clr_hi) |=> hi == CW'($past(hi) + 1'b1)); // R8

endmodule

bind evt_cnt_pair evt_cnt_pair_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .casc(casc_q),
  .clr_lo(clr_lo), .clr_hi(clr_hi), .ovf(ovf_lo_o), .lo(lo_q), .hi(hi_q)
);

// File: tb/sim_evt_cnt_pair.sv
module sim_evt_cnt_pair;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {select code, window in units of 8 cycles, expected count}
  localparam int VEC [NV][3] = '{'{1, 2, 8}, '{2, 4, 8}, '{3, 4, 4}, '{1, 1, 4}, '{2, 1, 2}};

  logic clk = 1'b0, rst_n = 1'b0, evt_lo = 1'b0, evt_hi = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic ovf;
  int n_chk = 0, n_bad = 0, ovf_cnt = 0;
  bit done = 0;

  evt_cnt_pair u0 (.clk(clk), .rst_n(rst_n), .evt_lo_i(evt_lo), .evt_hi_i(evt_hi),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .ovf_lo_o(ovf));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (ovf) ovf_cnt++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk); addr = a; #1;
    n_chk++;
    if (rdata !== 8'(exp)) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %0d expected %0d", req, a, rdata, exp);
    end
  endtask

  task automatic chk_val(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(2'd0, 8'h20, "R1");
    chk(2'd2, 0, "R1");
    chk(2'd3, 0, "R1");

    // R2 / R3 prescaler taps from the vector table
    for (int i = 0; i < NV; i++) begin
      int s;
      s = VEC[i][0];
      wr(2'd0, 8'((s << 2) | s));
      wr(2'd1, 8'h03);
      wr(2'd0, 8'(32 | (s << 2) | s));
      wait_cyc(8 * VEC[i][1] - 1);
      wr(2'd0, 8'((s << 2) | s));
      chk(2'd2, VEC[i][2], "R2");
      chk(2'd3, VEC[i][2], "R3");
    end

    // R4 pin events: five low pulses, one long high pulse
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h20);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); evt_lo = 1'b1;
      if (p == 0) evt_hi = 1'b1;
      wait_cyc(3);
      @(negedge clk); evt_lo = 1'b0;
      wait_cyc(3);
    end
    @(negedge clk); evt_hi = 1'b0;
    wait_cyc(5);
    chk(2'd2, 5, "R4");
    chk(2'd3, 1, "R4");

    // R6 standby: prescaler and pin activity are ignored
    wr(2'd0, 8'h05);
    wait_cyc(20);
    @(negedge clk); evt_lo = 1'b1; evt_hi = 1'b1;
    wait_cyc(4);
    @(negedge clk); evt_lo = 1'b0; evt_hi = 1'b0;
    wait_cyc(5);
    chk(2'd2, 5, "R6");
    chk(2'd3, 1, "R6");

    // R9 writes to count addresses are ignored
    wr(2'd2, 8'h55);
    wr(2'd3, 8'hAA);
    chk(2'd2, 5, "R9");
    chk(2'd3, 1, "R9");

    // R5 independent clears
    wr(2'd1, 8'h01);
    chk(2'd2, 0, "R5");
    chk(2'd3, 1, "R5");
    // R5 clear beats count on back-to-back edges while /2 runs
    wr(2'd0, 8'h21);
    wr(2'd1, 8'h01);
    chk(2'd2, 0, "R5");
    wr(2'd1, 8'h01);
    chk(2'd2, 0, "R5");

    // R7 / R8 chained: low /2, high select /8 overridden
    wr(2'd0, 8'h1D);
    wr(2'd1, 8'h03);
    ovf_cnt = 0;
    wr(2'd0, 8'h3D);
    wait_cyc(575);
    wr(2'd0, 8'h1D);
    chk(2'd2, 32, "R7");
    chk(2'd3, 1, "R8");
    chk_val(ovf_cnt, 1, "R7");

    // R8 unchained: high counts its own /8 tap, wrap ignored
    wr(2'd0, 8'h0D);
    wr(2'd1, 8'h03);
    ovf_cnt = 0;
    wr(2'd0, 8'h2D);
    wait_cyc(575);
    wr(2'd0, 8'h0D);
    chk(2'd2, 32, "R8");
    chk(2'd3, 72, "R8");
    chk_val(ovf_cnt, 1, "R7");

    finish_up();
  end
endmodule